// File: doc/BRIEF.md
# I2C Multi-Master Start Condition Generator

This block issues an I2C Start condition on a bus shared with other masters. It drives open-drain pull-down enables for both bus lines. It watches the resolved line levels through a small synchronizer, so it can tell when another master interferes. A one-cycle request pulse begins the sequence. A 7-bit reload value sets how long each of the two timed phases lasts, measured in system clocks.

The sequence runs in phases. First the block checks that both lines are high. Then it waits one timed phase with SDA released, and pulls SDA low. It waits a second timed phase and then pulls SCL low. At that point it raises a one-cycle completion pulse and holds both lines low until a release pulse hands the bus to the next stage.

Another master can pull SDA low during the first phase. The block does not treat this as a loss: it cuts the wait short and asserts SDA straight away. SCL falling while SDA is still high in the first phase does count as a loss. So does finding either line low when the request arrives. Both cases release the lines and set a sticky collision flag. Separate sticky flags record any Start seen on the bus and any event that needs service. All flags stay set until a software clear pulse.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, both pull enables, `done`, `busy` and all three flags are 0.
- R2: If the synchronized SDA or SCL is low when `start_req` is accepted in idle, no line is pulled, `busy` stays 0 and `coll_flag` is 1 two clocks after the request edge.
- R3: With both lines high, the request is accepted on its clock edge, `busy` rises, and `sda_pull` rises N+1 clocks later, where N is `reload`, or 1 when `reload` is 0.
- R4: `scl_pull` and a one-cycle `done` pulse rise N+1 clocks after `sda_pull`. Both pulls then stay asserted.
- R5: During the first phase, if the synchronized SCL is low while the synchronized SDA is high, the block releases both lines, returns to idle without `done`, and sets `coll_flag`.
- R6: During the first phase, another master's low on SDA makes the block assert `sda_pull` on the clock after it is seen at the synchronizer output (SYNC_STAGES clocks of input latency). The block then restarts the timer and sets no collision.
- R7: During the second phase, SCL held low by another master is not a collision, and `done` arrives at the normal time.
- R8: `start_seen` is set when the synchronized SDA falls while the synchronized SCL is high, whether the block or another master caused it. `irq_flag` is set by such a fall, by a collision or by `done`.
- R9: `coll_flag`, `start_seen` and `irq_flag` stay set until `sw_clear` is pulsed. If a set and a clear arrive in the same cycle, the flag is set.
- R10: `start_req` has no effect while a sequence is running or while the lines are held after completion.
- R11: A `bus_release` pulse in the hold phase releases both lines on the next clock and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle pulse that requests a Start |
| reload | input | 7 | Phase length in clocks (0 acts as 1) |
| bus_release | input | 1 | Pulse that releases the held lines after completion |
| sw_clear | input | 1 | Pulse that clears the sticky flags |
| sda_in | input | 1 | Resolved SDA level from the bus |
| scl_in | input | 1 | Resolved SCL level from the bus |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 |
| done | output | 1 | One-cycle pulse when the Start is complete |
| busy | output | 1 | Sequence in progress (request bit) |
| coll_flag | output | 1 | Sticky bus-collision flag |
| start_seen | output | 1 | Sticky flag: Start detected on the bus |
| irq_flag | output | 1 | Sticky service flag |

## Verification
The bench uses the default RELOAD_W of 7 and a SYNC_STAGES of 2. This lets it reach the zero reload, the reload of 1 and the full 127-clock phase, and it also sets the exact cycle at which outside interference is seen. The bench models the bus as wired-AND with an outside master. It places SDA or SCL interference at chosen clocks inside each phase. It computes, for each reload and offset, the clock at which `sda_pull`, `done` and `coll_flag` must first appear.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_SDA = 2'd1,
    ST_WAIT_SCL = 2'd2,
    ST_HOLD     = 2'd3
  } start_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_raw,
  input  logic scl_raw,
  output logic sda_s,
  output logic scl_s,
  output logic start_det
);
  logic [STAGES-1:0] sda_chain;
  logic [STAGES-1:0] scl_chain;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sda_chain <= 1'b1;
          scl_chain <= 1'b1;
        end else begin
          sda_chain <= sda_raw;
          scl_chain <= scl_raw;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          sda_chain <= '1;
          scl_chain <= '1;
        end else begin
          sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
          scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sda_prev <= 1'b1;
    else     sda_prev <= sda_chain[STAGES-1];
  end

  assign sda_s     = sda_chain[STAGES-1];
  assign scl_s     = scl_chain[STAGES-1];
  assign start_det = sda_prev & ~sda_s & scl_s;
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= (load_val == '0) ? ONE : load_val;
    else if (cnt != '0)    cnt <= cnt - ONE;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic bus_release,
  input  logic sda_s,
  input  logic scl_s,
  input  logic t_zero,
  output logic t_load,
  output logic sda_pull,
  output logic scl_pull,
  output logic done,
  output logic coll_pulse,
  output logic busy
);
  start_state_t state;
  logic         scl_stolen;

  assign scl_stolen = ~scl_s & sda_s;

  always_comb begin
    t_load = 1'b0;
    case (state)
      ST_IDLE:     t_load = start_req & sda_s & scl_s;
      ST_WAIT_SDA: t_load = ~scl_stolen & (~sda_s | t_zero);
      default:     t_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sda_pull   <= 1'b0;
      scl_pull   <= 1'b0;
      done       <= 1'b0;
      coll_pulse <= 1'b0;
    end else begin
      done       <= 1'b0;
      coll_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            if (sda_s && scl_s) state <= ST_WAIT_SDA;
            else                coll_pulse <= 1'b1;
          end
        end
        ST_WAIT_SDA: begin
          if (scl_stolen) begin
            coll_pulse <= 1'b1;
            sda_pull   <= 1'b0;
            scl_pull   <= 1'b0;
            state      <= ST_IDLE;
          end else if (!sda_s || t_zero) begin
            sda_pull <= 1'b1;
            state    <= ST_WAIT_SCL;
          end
        end
        ST_WAIT_SCL: begin
          if (t_zero) begin
            scl_pull <= 1'b1;
            done     <= 1'b1;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (bus_release) begin
            sda_pull <= 1'b0;
            scl_pull <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WAIT_SDA) || (state == ST_WAIT_SCL);
endmodule

// File: rtl/i2c_start_flags.sv
module i2c_start_flags (
  input  logic clk,
  input  logic rst,
  input  logic sw_clear,
  input  logic coll_pulse,
  input  logic start_det,
  input  logic done,
  output logic coll_flag,
  output logic start_seen,
  output logic irq_flag
);
  logic irq_set;
  assign irq_set = coll_pulse | start_det | done;

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_flag  <= 1'b0;
      start_seen <= 1'b0;
      irq_flag   <= 1'b0;
    end else begin
      coll_flag  <= coll_pulse | (coll_flag  & ~sw_clear);
      start_seen <= start_det  | (start_seen & ~sw_clear);
      irq_flag   <= irq_set    | (irq_flag   & ~sw_clear);
    end
  end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                bus_release,
  input  logic                sw_clear,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_pull,
  output logic                scl_pull,
  output logic                done,
  output logic                busy,
  output logic                coll_flag,
  output logic                start_seen,
  output logic                irq_flag
);
  logic sda_s, scl_s, start_det;
  logic t_load, t_zero, coll_pulse;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .sda_raw   (sda_in),
    .scl_raw   (scl_in),
    .sda_s     (sda_s),
    .scl_s     (scl_s),
    .start_det (start_det)
  );

  i2c_baud_timer #(.W(RELOAD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (reload),
    .zero     (t_zero)
  );

  i2c_start_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .bus_release (bus_release),
    .sda_s       (sda_s),
    .scl_s       (scl_s),
    .t_zero      (t_zero),
    .t_load      (t_load),
    .sda_pull    (sda_pull),
    .scl_pull    (scl_pull),
    .done        (done),
    .coll_pulse  (coll_pulse),
    .busy        (busy)
  );

  i2c_start_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .sw_clear   (sw_clear),
    .coll_pulse (coll_pulse),
    .start_det  (start_det),
    .done       (done),
    .coll_flag  (coll_flag),
    .start_seen (start_seen),
    .irq_flag   (irq_flag)
  );
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
  input logic clk,
  input logic rst,
  input logic sw_clear,
  input logic sda_pull,
  input logic scl_pull,
  input logic done,
  input logic busy,
  input logic coll_flag
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_DONE_LINES_LOW: assert property (@(posedge clk) disable iff (rst) done |-> (sda_pull && scl_pull)); // R4
  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (rst) $rose(scl_pull) |-> sda_pull); // R4
  AST_BUSY_SCL_FREE: assert property (@(posedge clk) disable iff (rst) busy |-> !scl_pull); // R3
  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (rst) $rose(coll_flag) |-> (!sda_pull && !scl_pull)); // R5
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (rst) (coll_flag && !sw_clear) |=> coll_flag); // R9
endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_clear  (sw_clear),
  .sda_pull  (sda_pull),
  .scl_pull  (scl_pull),
  .done      (done),
  .busy      (busy),
  .coll_flag (coll_flag)
);

// File: tb/i2c_start_gen_test.sv
module i2c_start_gen_test;
  localparam int S = 2;
  localparam int K_NORM = 0, K_EARLY = 1, K_SCLCOL = 2, K_ABORT_SDA = 3,
                 K_ABORT_SCL = 4, K_SCL2 = 5, K_REREQ = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, bus_release = 1'b0, sw_clear = 1'b0;
  logic [6:0] reload = 7'd0;
  logic ext_sda = 1'b0, ext_scl = 1'b0;
  logic sda_in, scl_in;
  logic sda_pull, scl_pull, done, busy, coll_flag, start_seen, irq_flag;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign sda_in = ~(sda_pull | ext_sda);
  assign scl_in = ~(scl_pull | ext_scl);

  i2c_start_gen #(.RELOAD_W(7), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .reload(reload),
    .bus_release(bus_release), .sw_clear(sw_clear),
    .sda_in(sda_in), .scl_in(scl_in),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .done(done), .busy(busy),
    .coll_flag(coll_flag), .start_seen(start_seen), .irq_flag(irq_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit completes(input int kind);
    return kind == K_NORM || kind == K_EARLY || kind == K_SCL2 || kind == K_REREQ;
  endfunction

  function automatic int sda_at(input int kind, input int n, input int j);
    if (kind == K_EARLY) return ((j + S < n + 1) ? j + S : n + 1) + 1;
    if (completes(kind)) return n + 2;
    return 0;
  endfunction

  function automatic int done_at(input int kind, input int n, input int j);
    if (completes(kind)) return sda_at(kind, n, j) + n + 1;
    return 0;
  endfunction

  function automatic int coll_at(input int kind, input int j);
    if (kind == K_ABORT_SDA || kind == K_ABORT_SCL) return 2;
    if (kind == K_SCLCOL) return j + S + 2;
    return 0;
  endfunction

  function automatic bit seen_exp(input int kind);
    return !(kind == K_ABORT_SCL || kind == K_SCLCOL);
  endfunction

  task automatic run_trial(input int kind, input int r, input int j);
    int n, i_sda, i_done, i_coll, dcount, busy1;
    n = (r == 0) ? 1 : r;
    i_sda = 0; i_done = 0; i_coll = 0; dcount = 0; busy1 = 0;
    if (kind == K_ABORT_SDA || kind == K_ABORT_SCL) begin
      @(negedge clk);
      if (kind == K_ABORT_SDA) ext_sda = 1'b1; else ext_scl = 1'b1;
      repeat (4) @(negedge clk);
    end
    @(negedge clk);
    reload = 7'(r);
    start_req = 1'b1;
    for (int k = 1; k <= 2 * n + 10; k++) begin
      @(negedge clk);
      if (sda_pull && i_sda == 0) i_sda = k;
      if (done) begin dcount++; if (i_done == 0) i_done = k; end
      if (coll_flag && i_coll == 0) i_coll = k;
      if (k == 1) busy1 = busy;
      start_req = (kind == K_REREQ) && (k == 2 || k == 2 * n + 4);
      if (kind == K_EARLY && k == j) ext_sda = 1'b1;
      if ((kind == K_SCLCOL || kind == K_SCL2) && k == j) ext_scl = 1'b1;
    end
    chk(i_sda == sda_at(kind, n, j), (kind == K_EARLY) ? "R6 sda clock" : "R3 sda clock",
        i_sda, sda_at(kind, n, j));
    chk(i_done == done_at(kind, n, j), (kind == K_SCL2) ? "R7 done clock" : "R4 done clock",
        i_done, done_at(kind, n, j));
    chk(i_coll == coll_at(kind, j), (kind == K_SCLCOL) ? "R5 collision" : "R2 collision",
        i_coll, coll_at(kind, j));
    chk(dcount == int'(completes(kind)), "R10 done count", dcount, int'(completes(kind)));
    chk(busy1 == int'(!(kind == K_ABORT_SDA || kind == K_ABORT_SCL)), "R3 busy",
        busy1, int'(!(kind == K_ABORT_SDA || kind == K_ABORT_SCL)));
    chk((sda_pull & scl_pull) == completes(kind), "R4 lines held",
        int'(sda_pull & scl_pull), int'(completes(kind)));
    chk(start_seen == seen_exp(kind), "R8 start_seen", start_seen, int'(seen_exp(kind)));
    chk(irq_flag == 1'b1, "R8 irq_flag", irq_flag, 1);
    @(negedge clk);
    bus_release = 1'b1;
    ext_sda = 1'b0;
    ext_scl = 1'b0;
    @(negedge clk);
    bus_release = 1'b0;
    chk(!sda_pull && !scl_pull, "R11 release", int'(sda_pull | scl_pull), 0);
    repeat (4) @(negedge clk);
    chk(coll_flag == (coll_at(kind, j) != 0), "R9 sticky", coll_flag, int'(coll_at(kind, j) != 0));
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
    chk(!coll_flag && !start_seen && !irq_flag, "R9 clear",
        int'({coll_flag, start_seen, irq_flag}), 0);
  endtask

  initial begin
    int kind, r, j, n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({sda_pull, scl_pull, done, busy, coll_flag, start_seen, irq_flag} == 7'b0,
        "R1 reset", int'({sda_pull, scl_pull, done, busy, coll_flag, start_seen, irq_flag}), 0);
    run_trial(K_NORM, 0, 0);
    run_trial(K_NORM, 1, 0);
    run_trial(K_NORM, 127, 0);
    run_trial(K_EARLY, 10, 1);
    run_trial(K_EARLY, 10, 9);
    run_trial(K_SCLCOL, 2, 1);
    run_trial(K_SCLCOL, 20, 7);
    run_trial(K_ABORT_SDA, 5, 0);
    run_trial(K_ABORT_SCL, 5, 0);
    run_trial(K_SCL2, 1, 4);
    run_trial(K_SCL2, 8, 15);
    run_trial(K_REREQ, 6, 0);
    for (int t = 0; t < 40; t++) begin
      kind = int'($urandom % 7);
      r = int'($urandom % 128);
      if ((kind == K_SCLCOL || kind == K_EARLY) && r < 2) r = 2;
      n = (r == 0) ? 1 : r;
      case (kind)
        K_EARLY:  j = 1 + int'($urandom % n);
        K_SCLCOL: j = 1 + int'($urandom % (n - 1));
        K_SCL2:   j = n + 3 + int'($urandom % n);
        default:  j = 0;
      endcase
      run_trial(kind, r, j);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule